// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

The engine walks a circular list of transmit descriptors held in a small local store. Each descriptor is 64 bits wide: a 16-bit control/status word, a 16-bit frame length and a 32-bit buffer address. Software writes whole descriptors through a write port and reads them back through a read port. It hands a descriptor to the engine by setting its ownership bit, and then writes the restart strobe to wake a halted engine.

For every owned descriptor, the engine presents the buffer address and length to a downstream MAC and holds that request until the MAC reports completion. It then writes the status word back with ownership cleared, and an error flag when the MAC reported a failure. After that it moves to the next descriptor, or back to slot offset 0 when the descriptor carried the wrap flag. An unowned descriptor parks the engine in a halt state until the next restart strobe.

A graceful-stop request lets the frame in flight finish and then parks the engine. This is acknowledged through a write-one-to-clear event bit. A second event bit reports completed frames that asked for notification.

The controller has five states:
- HALT is the reset state and waits for the restart strobe.
- FETCH inspects the descriptor at the current position.
- SEND holds the request to the MAC.
- WRITEBACK updates the status word and moves the position.
- STOP is the graceful-stop park.

The state transitions are:
- HALT→FETCH on the restart strobe.
- FETCH→STOP when a stop is requested.
- FETCH→SEND when the descriptor is owned.
- FETCH→HALT when the descriptor is not owned.
- SEND→WRITEBACK on MAC completion.
- WRITEBACK→STOP when a stop is requested.
- WRITEBACK→FETCH otherwise.
- STOP→FETCH when the stop request falls.

Top module: `tx_desc_ring`

## Requirements
- R1: After reset the engine is halted (`halted`=1), `stopped`=0, `cur_idx`=0, no request is issued and both event bits read 0.
- R2: A `clr_halt` strobe makes the engine inspect the descriptor at the current position. If its ownership bit (status bit 15) is set, it raises `mac_req_valid` with that descriptor's address and length, and holds all three steady until `mac_done`.
- R3: On completion the descriptor's status word is rewritten with bit 15 cleared and every other bit kept. When `mac_err` accompanied `mac_done`, bit 0 is also set. `mac_req_valid` drops in the cycle after `mac_done`.
- R4: After a completed descriptor the position advances by one, or returns to offset 0 when that descriptor's wrap bit (status bit 13) was set.
- R5: A descriptor whose bit 15 is clear sends nothing, leaves the position unchanged and sets `halted`. The engine stays halted, even if descriptors become owned, until the next `clr_halt`.
- R6: While `gts_req` is high, the frame in flight completes but no new request is started. The engine asserts `stopped` and sets `evt_gtsc`. When `gts_req` falls, it resumes at the current position.
- R7: Completion of a descriptor with the notify bit (status bit 12) set raises `evt_txf`. Completion of a descriptor without it leaves `evt_txf` unchanged.
- R8: Event bits are write-one-to-clear: `evt_clr[0]` clears `evt_txf` and `evt_clr[1]` clears `evt_gtsc`.
- R9: The store slot used for position p is (`ring_base` + p) modulo the store depth, so `ring_base` relocates offset 0 of the ring.
- R10: The read port returns the full descriptor in the format {status, length, address}, with status in bits 63:48, length in bits 47:32 and address in bits 31:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_we | input | 1 | Software descriptor write enable |
| sw_waddr | input | 3 | Slot written by software |
| sw_wdata | input | 64 | Descriptor written {status, length, address} |
| sw_raddr | input | 3 | Slot read by software |
| sw_rdata | output | 64 | Descriptor at `sw_raddr` |
| ring_base | input | 3 | Slot holding ring offset 0 |
| clr_halt | input | 1 | Restart strobe |
| gts_req | input | 1 | Graceful stop request (level) |
| evt_clr | input | 2 | Write-one-to-clear for the event bits |
| mac_req_valid | output | 1 | Frame send request to the MAC |
| mac_req_ptr | output | 32 | Buffer address of the requested frame |
| mac_req_len | output | 16 | Length of the requested frame |
| mac_done | input | 1 | MAC completion pulse |
| mac_err | input | 1 | MAC reports failure, sampled with `mac_done` |
| halted | output | 1 | Engine is in the halt state |
| stopped | output | 1 | Engine is parked by a graceful stop |
| cur_idx | output | 3 | Current ring position (offset from `ring_base`) |
| evt_txf | output | 1 | Notified-frame-done event |
| evt_gtsc | output | 1 | Graceful-stop-complete event |

## Verification
The first pattern is a run of two owned descriptors ending at an unowned one. It confirms that requests carry each descriptor's own address and length, that ownership is returned with the other control bits intact, and that the engine halts on the unowned slot. A run that crosses the wrap flag while one frame draws a MAC error separates wrap-driven return to offset 0 from plain counting, and shows the error flag landing only in the failing descriptor.

Making a descriptor owned while the engine is halted, without a restart, shows that ownership alone does not wake it. Raising the stop request mid-frame distinguishes a graceful stop from a halt: the next owned descriptor stays untouched until the request falls. A final run with a nonzero ring base relocates every slot and confirms that wrap returns to the relocated offset 0.

// File: rtl/tdre_pkg.sv
package tdre_pkg;
    localparam int ST_W  = 16;
    localparam int LEN_W = 16;
    localparam int PTR_W = 32;

    // Status word bits the engine decodes or writes
    localparam int B_OWN  = 15;
    localparam int B_WRAP = 13;
    localparam int B_NOTE = 12;
    localparam int B_ERR  = 0;

    typedef struct packed {
        logic [ST_W-1:0]  status;
        logic [LEN_W-1:0] len;
        logic [PTR_W-1:0] ptr;
    } desc_t;

    localparam int DESC_W = $bits(desc_t);

    typedef enum logic [2:0] {
        S_HALT,
        S_FETCH,
        S_SEND,
        S_WB,
        S_STOP
    } eng_state_t;
endpackage

// File: rtl/tdre_desc_mem.sv
module tdre_desc_mem
    import tdre_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_we,
    input  logic [AW-1:0]   sw_waddr,
    input  desc_t           sw_wdata,
    input  logic            wb_en,
    input  logic [AW-1:0]   wb_addr,
    input  logic [ST_W-1:0] wb_status,
    input  logic [AW-1:0]   sw_raddr,
    output desc_t           sw_rdata,
    input  logic [AW-1:0]   eng_raddr,
    output desc_t           eng_rdata
);
    desc_t slots [DEPTH];

    // Engine status write-back is applied last and so wins a same-slot clash
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= '0;
            end
        end else begin
            if (sw_we) begin
                slots[sw_waddr] <= sw_wdata;
            end
            if (wb_en) begin
                slots[wb_addr].status <= wb_status;
            end
        end
    end

    assign sw_rdata  = slots[sw_raddr];
    assign eng_rdata = slots[eng_raddr];
endmodule

// File: rtl/tdre_events.sv
module tdre_events #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] evt
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                evt[g] <= 1'b0;
            end else if (set[g]) begin
                evt[g] <= 1'b1;
            end else if (clr[g]) begin
                evt[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tdre_ctrl.sv
module tdre_ctrl
    import tdre_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_halt,
    input  logic             gts_req,
    input  logic [AW-1:0]    ring_base,
    input  desc_t            rd_desc,
    input  logic             mac_done,
    input  logic             mac_err,
    output logic [AW-1:0]    slot_addr,
    output logic [AW-1:0]    cur_off,
    output logic             wb_en,
    output logic [ST_W-1:0]  wb_status,
    output logic             mac_req_valid,
    output logic [PTR_W-1:0] mac_req_ptr,
    output logic [LEN_W-1:0] mac_req_len,
    output logic             halted,
    output logic             stopped,
    output logic             set_txf,
    output logic             set_gtsc
);
    eng_state_t state, nxt;
    desc_t      held;
    logic       err_q;

    assign slot_addr = ring_base + cur_off;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_HALT;
        end else begin
            state <= nxt;
        end
    end

    // Transition logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_HALT:  if (clr_halt) nxt = S_FETCH;
            S_FETCH: begin
                if (gts_req)                        nxt = S_STOP;
                else if (rd_desc.status[B_OWN])     nxt = S_SEND;
                else                                nxt = S_HALT;
            end
            S_SEND:  if (mac_done) nxt = S_WB;
            S_WB:    nxt = gts_req ? S_STOP : S_FETCH;
            S_STOP:  if (!gts_req) nxt = S_FETCH;
            default: nxt = S_HALT;
        endcase
    end

    // Outputs
    always_comb begin
        wb_en         = 1'b0;
        wb_status     = held.status;
        wb_status[B_OWN] = 1'b0;
        if (err_q) wb_status[B_ERR] = 1'b1;
        mac_req_valid = 1'b0;
        halted        = 1'b0;
        stopped       = 1'b0;
        set_txf       = 1'b0;
        set_gtsc      = 1'b0;
        unique case (state)
            S_HALT:  halted = 1'b1;
            S_FETCH: set_gtsc = gts_req;
            S_SEND:  mac_req_valid = 1'b1;
            S_WB: begin
                wb_en    = 1'b1;
                set_txf  = held.status[B_NOTE];
                set_gtsc = gts_req;
            end
            S_STOP:  stopped = 1'b1;
            default: halted = 1'b1;
        endcase
    end

    assign mac_req_ptr = held.ptr;
    assign mac_req_len = held.len;

    // Descriptor capture, completion status and ring position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held    <= '0;
            err_q   <= 1'b0;
            cur_off <= '0;
        end else begin
            unique case (state)
                S_FETCH: begin
                    if (!gts_req && rd_desc.status[B_OWN]) begin
                        held  <= rd_desc;
                        err_q <= 1'b0;
                    end
                end
                S_SEND: begin
                    if (mac_done) err_q <= mac_err;
                end
                S_WB: begin
                    cur_off <= held.status[B_WRAP] ? '0 : cur_off + 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tx_desc_ring.sv
module tx_desc_ring
    import tdre_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [AW-1:0]     sw_waddr,
    input  logic [DESC_W-1:0] sw_wdata,
    input  logic [AW-1:0]     sw_raddr,
    output logic [DESC_W-1:0] sw_rdata,
    input  logic [AW-1:0]     ring_base,
    input  logic              clr_halt,
    input  logic              gts_req,
    input  logic [1:0]        evt_clr,
    output logic              mac_req_valid,
    output logic [PTR_W-1:0]  mac_req_ptr,
    output logic [LEN_W-1:0]  mac_req_len,
    input  logic              mac_done,
    input  logic              mac_err,
    output logic              halted,
    output logic              stopped,
    output logic [AW-1:0]     cur_idx,
    output logic              evt_txf,
    output logic              evt_gtsc
);
    desc_t           eng_desc;
    desc_t           rd_view;
    logic [AW-1:0]   slot_addr;
    logic            wb_en;
    logic [ST_W-1:0] wb_status;
    logic            set_txf;
    logic            set_gtsc;
    logic [1:0]      evt_q;

    tdre_desc_mem #(.DEPTH(DEPTH)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_we     (sw_we),
        .sw_waddr  (sw_waddr),
        .sw_wdata  (desc_t'(sw_wdata)),
        .wb_en     (wb_en),
        .wb_addr   (slot_addr),
        .wb_status (wb_status),
        .sw_raddr  (sw_raddr),
        .sw_rdata  (rd_view),
        .eng_raddr (slot_addr),
        .eng_rdata (eng_desc)
    );

    assign sw_rdata = rd_view;

    tdre_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr_halt      (clr_halt),
        .gts_req       (gts_req),
        .ring_base     (ring_base),
        .rd_desc       (eng_desc),
        .mac_done      (mac_done),
        .mac_err       (mac_err),
        .slot_addr     (slot_addr),
        .cur_off       (cur_idx),
        .wb_en         (wb_en),
        .wb_status     (wb_status),
        .mac_req_valid (mac_req_valid),
        .mac_req_ptr   (mac_req_ptr),
        .mac_req_len   (mac_req_len),
        .halted        (halted),
        .stopped       (stopped),
        .set_txf       (set_txf),
        .set_gtsc      (set_gtsc)
    );

    tdre_events #(.N(2)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .set   ({set_gtsc, set_txf}),
        .clr   (evt_clr),
        .evt   (evt_q)
    );

    assign evt_txf  = evt_q[0];
    assign evt_gtsc = evt_q[1];
endmodule

// File: rtl/tx_desc_ring_chk.sv
module tx_desc_ring_chk #(
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr_halt,
    input logic          gts_req,
    input logic          mac_req_valid,
    input logic [31:0]   mac_req_ptr,
    input logic [15:0]   mac_req_len,
    input logic          mac_done,
    input logic          halted,
    input logic          stopped,
    input logic [AW-1:0] cur_idx
);
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mac_req_valid && !mac_done |=> mac_req_valid && $stable(mac_req_ptr) && $stable(mac_req_len));

    assert_req_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mac_req_valid && mac_done |=> !mac_req_valid);

    assert_halt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        halted && !clr_halt |=> halted && $stable(cur_idx));

    assert_stop_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stopped && gts_req |=> stopped && !mac_req_valid);

    assert_idle_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({halted, stopped, mac_req_valid}));
endmodule

bind tx_desc_ring tx_desc_ring_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr_halt      (clr_halt),
    .gts_req       (gts_req),
    .mac_req_valid (mac_req_valid),
    .mac_req_ptr   (mac_req_ptr),
    .mac_req_len   (mac_req_len),
    .mac_done      (mac_done),
    .halted        (halted),
    .stopped       (stopped),
    .cur_idx       (cur_idx)
);

// File: tb/tx_desc_ring_bench.sv
`timescale 1ns/1ps
module tx_desc_ring_bench;
    localparam logic [15:0] OWN  = 16'h8000;
    localparam logic [15:0] WRP  = 16'h2000;
    localparam logic [15:0] NOTE = 16'h1000;
    localparam logic [15:0] LST  = 16'h0800;
    localparam logic [15:0] CRC  = 16'h0400;
    localparam logic [15:0] ERRB = 16'h0001;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sw_we;
    logic [2:0]  sw_waddr;
    logic [63:0] sw_wdata;
    logic [2:0]  sw_raddr;
    logic [63:0] sw_rdata;
    logic [2:0]  ring_base;
    logic        clr_halt;
    logic        gts_req;
    logic [1:0]  evt_clr;
    logic        mac_req_valid;
    logic [31:0] mac_req_ptr;
    logic [15:0] mac_req_len;
    logic        mac_done;
    logic        mac_err;
    logic        halted;
    logic        stopped;
    logic [2:0]  cur_idx;
    logic        evt_txf;
    logic        evt_gtsc;

    int checks = 0;
    int errors = 0;
    int n_req  = 0;
    logic [31:0] log_ptr [32];
    logic [15:0] log_len [32];

    always #2.5 clk = ~clk;

    tx_desc_ring u_tx_desc_ring (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_waddr(sw_waddr),
        .sw_wdata(sw_wdata), .sw_raddr(sw_raddr), .sw_rdata(sw_rdata),
        .ring_base(ring_base), .clr_halt(clr_halt), .gts_req(gts_req),
        .evt_clr(evt_clr), .mac_req_valid(mac_req_valid),
        .mac_req_ptr(mac_req_ptr), .mac_req_len(mac_req_len),
        .mac_done(mac_done), .mac_err(mac_err), .halted(halted),
        .stopped(stopped), .cur_idx(cur_idx), .evt_txf(evt_txf),
        .evt_gtsc(evt_gtsc)
    );

    // MAC stub: fails any buffer whose address has bit 31 set
    initial begin
        mac_done = 1'b0;
        mac_err  = 1'b0;
        forever begin
            @(negedge clk);
            if (mac_req_valid) begin
                if (n_req < 32) begin
                    log_ptr[n_req] = mac_req_ptr;
                    log_len[n_req] = mac_req_len;
                end
                n_req++;
                repeat (LAT - 1) @(negedge clk);
                mac_err  = mac_req_ptr[31];
                mac_done = 1'b1;
                @(negedge clk);
                mac_done = 1'b0;
                mac_err  = 1'b0;
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_desc(input logic [2:0] slot, input logic [15:0] st,
                           input logic [15:0] len, input logic [31:0] ptr);
        @(negedge clk);
        sw_we = 1'b1; sw_waddr = slot; sw_wdata = {st, len, ptr};
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic rd_status(input logic [2:0] slot, output logic [15:0] st);
        sw_raddr = slot;
        #0.1;
        st = sw_rdata[63:48];
    endtask

    task automatic kick();
        @(negedge clk);
        clr_halt = 1'b1;
        @(negedge clk);
        clr_halt = 1'b0;
    endtask

    task automatic wait_idle();
        int t = 0;
        repeat (3) @(negedge clk);
        while (!((halted || stopped) && !mac_req_valid) && t < 2000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 2000) check("idle-timeout", 0, 1);
    endtask

    task automatic t_reset();
        check("R1 halted", halted, 1);
        check("R1 stopped", stopped, 0);
        check("R1 cur_idx", cur_idx, 0);
        check("R1 req", mac_req_valid, 0);
        check("R1 events", {evt_gtsc, evt_txf}, 0);
    endtask

    task automatic t_basic();
        logic [15:0] st;
        int base = n_req;
        wr_desc(0, OWN | NOTE | LST | CRC, 16'd60, 32'h0000_1000);
        wr_desc(1, OWN | LST | CRC, 16'd100, 32'h0000_2000);
        kick();
        wait_idle();
        check("R2 request count", n_req - base, 2);
        check("R2 ptr0", log_ptr[base], 32'h0000_1000);
        check("R2 len0", log_len[base], 60);
        check("R2 ptr1", log_ptr[base+1], 32'h0000_2000);
        check("R2 len1", log_len[base+1], 100);
        rd_status(0, st);
        check("R3 R10 status0 own cleared", st, NOTE | LST | CRC);
        rd_status(1, st);
        check("R3 status1 own cleared", st, LST | CRC);
        check("R5 halted on unowned", halted, 1);
        check("R4 position after two", cur_idx, 2);
        check("R7 notify event", evt_txf, 1);
        @(negedge clk); evt_clr = 2'b01;
        @(negedge clk); evt_clr = 2'b00;
        check("R8 w1c txf", evt_txf, 0);
    endtask

    task automatic t_wrap_err();
        logic [15:0] st;
        int base = n_req;
        wr_desc(2, OWN | WRP | LST, 16'd64, 32'h8000_1000);
        wr_desc(0, OWN | CRC, 16'd1500, 32'h0000_3000);
        kick();
        wait_idle();
        check("R4 wrap request count", n_req - base, 2);
        check("R4 wrap order", log_ptr[base+1], 32'h0000_3000);
        rd_status(2, st);
        check("R3 error flag", st, WRP | LST | ERRB);
        rd_status(0, st);
        check("R3 no error flag", st, CRC);
        check("R4 position after wrap", cur_idx, 1);
        check("R7 no notify", evt_txf, 0);
    endtask

    task automatic t_halt_hold();
        int base;
        wr_desc(1, OWN, 16'd80, 32'h0000_4000);
        base = n_req;
        repeat (10) @(negedge clk);
        check("R5 no send while halted", n_req - base, 0);
        check("R5 still halted", halted, 1);
        kick();
        wait_idle();
        check("R5 restart sends", log_ptr[base], 32'h0000_4000);
        check("R4 position", cur_idx, 2);
    endtask

    task automatic t_gstop();
        logic [15:0] st;
        int base = n_req;
        wr_desc(2, OWN | WRP, 16'd70, 32'h0000_5000);
        wr_desc(0, OWN, 16'd90, 32'h0000_6000);
        kick();
        while (!mac_req_valid) @(negedge clk);
        gts_req = 1'b1;
        wait_idle();
        check("R6 stopped", stopped, 1);
        check("R6 one frame finished", n_req - base, 1);
        check("R6 gtsc event", evt_gtsc, 1);
        check("R6 position", cur_idx, 0);
        rd_status(0, st);
        check("R6 next still owned", st, OWN);
        repeat (5) @(negedge clk);
        check("R6 no send while stopped", n_req - base, 1);
        gts_req = 1'b0;
        wait_idle();
        check("R6 resumed", log_ptr[base+1], 32'h0000_6000);
        check("R6 halted after resume", halted, 1);
        @(negedge clk); evt_clr = 2'b10;
        @(negedge clk); evt_clr = 2'b00;
        check("R8 w1c gtsc", evt_gtsc, 0);
    endtask

    task automatic t_base();
        logic [15:0] st;
        int base = n_req;
        @(negedge clk); ring_base = 3'd4;
        wr_desc(5, OWN, 16'd11, 32'h0000_A000);
        wr_desc(6, OWN | WRP, 16'd22, 32'h0000_B000);
        wr_desc(4, OWN, 16'd33, 32'h0000_C000);
        kick();
        wait_idle();
        check("R9 count", n_req - base, 3);
        check("R9 first", log_ptr[base], 32'h0000_A000);
        check("R9 second", log_ptr[base+1], 32'h0000_B000);
        check("R9 wrapped to base", log_ptr[base+2], 32'h0000_C000);
        check("R9 len", log_len[base+2], 33);
        rd_status(5, st);
        check("R9 slot5 returned", st, 16'h0000);
        check("R9 position", cur_idx, 1);
    endtask

    initial begin
        #1000000;
        check("watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sw_we = 1'b0; sw_waddr = '0; sw_wdata = '0;
        sw_raddr = '0; ring_base = '0; clr_halt = 1'b0; gts_req = 1'b0;
        evt_clr = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_wrap_err();
        t_halt_hold();
        t_gstop();
        t_base();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule